// File: doc/BRIEF.md
# Transition-Density Loss-of-Signal Detector

This block watches a serial NRZ stream that has already been sampled once per unit interval (UI) and decides whether the line is alive. It runs in a single clock domain with one clock per UI; a valid strobe marks the cycles that carry a real sample. The loss flag rises after a long run with no transitions. It falls only when the recent past shows enough transitions, so rising and falling are judged by different tests. This gives the flag hysteresis against a line that toggles now and then.

While the flag is high, the data output is forced to zero. Two mode inputs, one for local loopback and one for receive monitoring, each switch detection off and hold the flag low. The quiet limit, the window length and the clear threshold are all parameters. The default quiet limit of 357 UI corresponds to roughly 2.3 us at a 155 MHz line rate.

Top module: `los_detector`

## Requirements
- R1: With no mode input high, `los` goes high on the clock edge that samples the QUIET_UI-th consecutive valid sample without a transition. A quiet run of QUIET_UI-1 samples leaves it low.
- R2: While `los` is high, it falls on the edge at which the last WIN_UI valid samples hold at least CLR_MIN transitions. With fewer transitions it stays high.
- R3: `data_out` shows the most recent valid `samp_bit` when `los` is low and shows 0 when `los` is high. It changes on the same edge as `los`, with no extra delay.
- R4: When `loop_mode` or `mon_mode` is high at an edge, `los` is low after that edge. The quiet counter and the density window keep running meanwhile.
- R5: A transition is a valid sample that differs from the previous valid sample. The first valid sample after reset is not a transition. Cycles with `samp_vld` low change neither counter nor the data output.
- R6: The quiet counter saturates at QUIET_UI and restarts from zero on every transition. After a saturated run under a mode input, releasing the mode input makes `los` high on the next edge.
- R7: Synchronous active-high `rst` leaves `los` at 1, `data_out` at 0, and both counters and the window cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one cycle per UI |
| rst | input | 1 | Synchronous active-high reset |
| samp_bit | input | 1 | Sampled line bit |
| samp_vld | input | 1 | High when samp_bit carries a real sample |
| loop_mode | input | 1 | Local loopback active; detection off |
| mon_mode | input | 1 | Receive monitor active; detection off |
| los | output | 1 | Loss-of-signal flag |
| data_out | output | 1 | Registered data, squelched to 0 during loss |

## Verification
The assertions assume that all inputs are known after reset and change only away from the rising clock edge. They also assume CLR_MIN does not exceed WIN_UI and that WIN_UI is smaller than QUIET_UI, so a set and a clear cannot compete in one cycle. The stimulus drives every input on the falling edge and uses a small configuration (quiet limit 12, window 8, threshold 3) that keeps this ordering. Random phases take valid strobes and bit flips from an LFSR and change the mode inputs only between samples.

// File: rtl/los_pkg.sv
package los_pkg;
  function automatic int width_for(input int maxv);
    return (maxv < 2) ? 1 : $clog2(maxv + 1);
  endfunction
endpackage

// File: rtl/los_edge_mark.sv
module los_edge_mark (
  input  logic clk,
  input  logic rst,
  input  logic samp_bit,
  input  logic samp_vld,
  output logic mark
);
  logic prev_bit;
  logic have_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_bit  <= 1'b0;
      have_prev <= 1'b0;
    end else if (samp_vld) begin
      prev_bit  <= samp_bit;
      have_prev <= 1'b1;
    end
  end

  assign mark = samp_vld & have_prev & (samp_bit ^ prev_bit);
endmodule

// File: rtl/los_quiet_timer.sv
module los_quiet_timer #(
  parameter int QUIET_UI = 357,
  parameter int CW       = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          samp_vld,
  input  logic          mark,
  output logic [CW-1:0] run_q,
  output logic          quiet_hit
);
  localparam logic [CW-1:0] QLIM = CW'(QUIET_UI);
  logic [CW-1:0] run_d;

  always_comb begin
    run_d = run_q;
    if (samp_vld) begin
      if (mark)              run_d = '0;
      else if (run_q != QLIM) run_d = run_q + 1'b1;
    end
  end

  assign quiet_hit = (run_d == QLIM);

  always_ff @(posedge clk) begin
    if (rst) run_q <= '0;
    else     run_q <= run_d;
  end

  assert_quiet_sat_R6: assert property (@(posedge clk) disable iff (rst)
    run_q <= QLIM);
  assert_quiet_restart_R6: assert property (@(posedge clk) disable iff (rst)
    (samp_vld && mark) |=> (run_q == '0));
endmodule

// File: rtl/los_density_window.sv
module los_density_window #(
  parameter int WIN_UI  = 32,
  parameter int CLR_MIN = 5,
  parameter int PW      = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          samp_vld,
  input  logic          mark,
  output logic [PW-1:0] pop_q,
  output logic          dense_hit
);
  logic [WIN_UI-1:0] hist;
  logic [PW-1:0]     pop_d;

  always_comb begin
    pop_d = pop_q;
    if (samp_vld)
      pop_d = pop_q + PW'(mark) - PW'(hist[WIN_UI-1]);
  end

  assign dense_hit = (pop_d >= PW'(CLR_MIN));

  always_ff @(posedge clk) begin
    if (rst) begin
      hist  <= '0;
      pop_q <= '0;
    end else begin
      if (samp_vld) hist <= {hist[WIN_UI-2:0], mark};
      pop_q <= pop_d;
    end
  end

  assert_pop_track_R2: assert property (@(posedge clk) disable iff (rst)
    int'(pop_q) == $countones(hist));
endmodule

// File: rtl/los_detector.sv
module los_detector #(
  parameter int QUIET_UI = 357,
  parameter int WIN_UI   = 32,
  parameter int CLR_MIN  = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic samp_bit,
  input  logic samp_vld,
  input  logic loop_mode,
  input  logic mon_mode,
  output logic los,
  output logic data_out
);
  localparam int QW = los_pkg::width_for(QUIET_UI);
  localparam int PW = los_pkg::width_for(WIN_UI);

  logic          mark;
  logic [QW-1:0] run_q;
  logic [PW-1:0] pop_q;
  logic          quiet_hit;
  logic          dense_hit;
  logic          los_d;
  logic          data_hold;
  logic          data_nxt;
  logic          det_off;

  los_edge_mark u_mark (
    .clk(clk), .rst(rst), .samp_bit(samp_bit), .samp_vld(samp_vld), .mark(mark)
  );

  los_quiet_timer #(.QUIET_UI(QUIET_UI), .CW(QW)) u_quiet (
    .clk(clk), .rst(rst), .samp_vld(samp_vld), .mark(mark),
    .run_q(run_q), .quiet_hit(quiet_hit)
  );

  los_density_window #(.WIN_UI(WIN_UI), .CLR_MIN(CLR_MIN), .PW(PW)) u_win (
    .clk(clk), .rst(rst), .samp_vld(samp_vld), .mark(mark),
    .pop_q(pop_q), .dense_hit(dense_hit)
  );

  assign det_off  = loop_mode | mon_mode;
  assign data_nxt = samp_vld ? samp_bit : data_hold;

  always_comb begin
    los_d = los;
    if (det_off)               los_d = 1'b0;
    else if (los && dense_hit) los_d = 1'b0;
    else if (!los && quiet_hit) los_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      los       <= 1'b1;
      data_hold <= 1'b0;
      data_out  <= 1'b0;
    end else begin
      los       <= los_d;
      data_hold <= data_nxt;
      data_out  <= data_nxt & ~los_d;
    end
  end

  assert_disable_R4: assert property (@(posedge clk) disable iff (rst)
    (loop_mode || mon_mode) |=> !los);
  assert_set_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    $rose(los) |-> (run_q == QW'(QUIET_UI)));
  assert_clear_dense_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(los) |-> ($past(det_off) || (pop_q >= PW'(CLR_MIN))));
  assert_squelch_R3: assert property (@(posedge clk) disable iff (rst)
    los |-> !data_out);
endmodule

// File: tb/tb_los_detector.sv
module tb_los_detector;
  localparam int CLK_PERIOD = 10;
  localparam int QUIET = 12;
  localparam int WIN   = 8;
  localparam int CLR   = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic samp_bit = 1'b0, samp_vld = 1'b0, loop_mode = 1'b0, mon_mode = 1'b0;
  logic los, data_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  bit m_prev, m_have, m_los, m_dq, m_out;
  int m_run;
  logic [WIN-1:0] m_hist;
  logic cur = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  always #(CLK_PERIOD/2) clk = ~clk;

  los_detector #(.QUIET_UI(QUIET), .WIN_UI(WIN), .CLR_MIN(CLR)) dut (
    .clk(clk), .rst(rst), .samp_bit(samp_bit), .samp_vld(samp_vld),
    .loop_mode(loop_mode), .mon_mode(mon_mode), .los(los), .data_out(data_out)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_prev = 0; m_have = 0; m_los = 1; m_dq = 0; m_out = 0; m_run = 0; m_hist = '0;
  endtask

  task automatic model_edge(input bit b, input bit v, input bit lp, input bit mn);
    bit t;
    int pop;
    t = 0;
    if (v) begin
      t = m_have && (b != m_prev);
      m_prev = b; m_have = 1; m_dq = b;
      m_hist = {m_hist[WIN-2:0], t};
      if (t) m_run = 0;
      else if (m_run < QUIET) m_run++;
    end
    pop = $countones(m_hist);
    if (lp || mn)                 m_los = 0;
    else if (m_los && pop >= CLR) m_los = 0;
    else if (!m_los && m_run == QUIET) m_los = 1;
    m_out = m_dq & !m_los;
  endtask

  // one UI: drive at falling edge, model at rising edge, compare at next falling edge
  task automatic step(input bit b, input bit v, input bit lp, input bit mn, input string tag);
    samp_bit = b; samp_vld = v; loop_mode = lp; mon_mode = mn;
    @(posedge clk);
    model_edge(b, v, lp, mn);
    @(negedge clk);
    check({tag, " los"}, los, m_los);
    check({"R3 data_out/", tag}, data_out, m_out);
  endtask

  task automatic do_reset();
    rst = 1'b1; samp_vld = 1'b0; loop_mode = 1'b0; mon_mode = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    model_reset();
    check("R7 reset los", los, 1'b1);
    check("R7 reset data_out", data_out, 1'b0);
  endtask

  task automatic toggles(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      cur = ~cur;
      step(cur, 1, 0, 0, tag);
    end
  endtask

  task automatic hold(input int n, input string tag);
    for (int i = 0; i < n; i++) step(cur, 1, 0, 0, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();

    // R7/R2: constant line after reset never clears the flag
    hold(30, "R2 idle");
    check("R2 idle stays lost", los, 1'b1);

    // R2: continuous toggling clears
    toggles(WIN, "R2 toggle");
    check("R2 toggling clears", los, 1'b0);

    // R1: quiet run sweep
    for (int len = 1; len <= QUIET + 3; len++) begin
      toggles(WIN, "R1 prep");
      hold(len, "R1 quiet");
      check($sformatf("R1 quiet len=%0d", len), los, (len >= QUIET));
    end

    // R2: density sweep by transition spacing
    for (int s = 1; s <= WIN + 2; s++) begin
      hold(QUIET + 2, "R2 prep");
      for (int i = 1; i <= 40; i++) begin
        if (i % s == 0) cur = ~cur;
        step(cur, 1, 0, 0, "R2 density");
      end
      check($sformatf("R2 spacing=%0d", s), los, !(((WIN - 1) / s) + 1 >= CLR));
    end

    // R5: invalid cycles ignored
    toggles(WIN, "R5 prep");
    for (int i = 0; i < 20; i++) step(i[0], 0, 0, 0, "R5 invalid");
    check("R5 no flag from invalid", los, 1'b0);
    check("R5 data held", data_out, cur);

    // R5: first sample after reset is not a transition
    do_reset();
    step(1, 1, 0, 0, "R5 first");
    step(1, 1, 0, 0, "R5 first");
    toggles(1, "R5 first");
    toggles(1, "R5 first");
    check("R5 first sample no mark", los, 1'b1);

    // R4/R6: mode inputs hold flag low; saturated counter sets on release
    toggles(WIN, "R4 prep");
    for (int i = 0; i < QUIET + 5; i++) step(cur, 1, 1, 0, "R4 loop");
    check("R4 loop holds low", los, 1'b0);
    step(cur, 1, 0, 0, "R6 release");
    check("R6 saturated sets on release", los, 1'b1);
    for (int i = 0; i < 4; i++) step(cur, 1, 0, 1, "R4 mon");
    check("R4 monitor forces low", los, 1'b0);
    step(cur, 0, 0, 0, "R6 release2");
    check("R6 release2", los, 1'b1);

    // mixed random phase
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (lfsr[5:3] == 3'd0 || (i > 1500 && lfsr[2:1] == 2'd0)) cur = ~cur;
      step(cur, lfsr[0] | lfsr[1], (lfsr[11:8] == 4'hF), 1'b0, "R1 R2 random");
    end

    // R7: reset mid-run
    toggles(WIN, "R7 prep");
    do_reset();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule